// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two square-wave phases of an incremental rotary or linear encoder into a signed 32-bit position. The phases are picked from a small bank of input pins. One pin index names phase A. A signed offset relative to that index names phase B, so an offset of +1 uses the next pin up. Each phase passes through a two-flop synchroniser. The synchronised pair is then decoded at every edge of either phase, which gives four counts per full quadrature cycle. A detented encoder that makes one full cycle per click therefore moves the count by 4 per click.

A single enable input both runs and clears the counter. While the enable is low, the count is held at zero. When the enable is raised again, counting starts from zero. The count cannot be loaded with any other starting value. The host can sample the position output at any time, and doing so has no effect on counting.

Top module: `qenc_counter`

## Requirements
- R1: After reset is released, `posCount` reads 0.
- R2: Each phase pair is read as `{A,B}`. A forward step (00 to 01, 01 to 11, 11 to 10, 10 to 00) adds 1 to `posCount`. A complete forward cycle adds 4.
- R3: A reverse step (00 to 10, 10 to 11, 11 to 01, 01 to 00) subtracts 1 from `posCount`.
- R4: A change of both phases at once (00 to 11, 11 to 00, 01 to 10, 10 to 01) leaves `posCount` unchanged.
- R5: While `enable` is low, `posCount` is 0 from the next clock edge on, whatever the phases do.
- R6: After `enable` rises again, counting resumes from 0.
- R7: Phase A is `pinsIn[aSel]`. Phase B is `pinsIn[(aSel + bOffset) mod 8]`, where `bOffset` is a 3-bit two's-complement value. All other pins have no effect on the count.
- R8: The count is 32-bit two's complement and wraps. One reverse step from 0 gives 0xFFFFFFFF.
- R9: A phase change is reflected on `posCount` no later than the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run when high; clear and hold at zero when low |
| pinsIn | input | 8 | Bank of input pins carrying the encoder phases |
| aSel | input | 3 | Index of the phase A pin |
| bOffset | input | 3 | Signed offset from phase A to the phase B pin |
| posCount | output | 32 | Current signed position count |

## Verification
A wrong history register shows up as an extra or missing count, or as a count in the wrong direction. It appears on `posCount` within three cycles of the phase edge that exposes it, and the error persists because the count is cumulative. A wrong pin-select offset causes counts to be lost or taken from a non-selected pin on the very next step. A fault in the clearing logic leaves a nonzero value after `enable` falls, or a stale value after `enable` rises, both visible within one cycle.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
  } qencStrobes_t;
endpackage

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int OFF_W  = 3,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [NUM_IN-1:0] pinsIn,
  input  logic [SEL_W-1:0]  aSel,
  input  logic [OFF_W-1:0]  bOffset,
  output qencStrobes_t      strb
);
  // Sign-extend the offset to the index width plus one bit.
  logic [SEL_W:0]   offExt;
  logic [SEL_W-1:0] bIdx;
  assign offExt = {{(SEL_W+1-OFF_W){bOffset[OFF_W-1]}}, bOffset};
  assign bIdx   = aSel + offExt[SEL_W-1:0];

  logic [1:0] rawState;
  assign rawState = {pinsIn[aSel], pinsIn[bIdx]};

  // Two-flop synchroniser for each phase, then one history register.
  logic [1:0] syncMeta, curState, prevState;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta  <= '0;
      curState  <= '0;
      prevState <= '0;
    end else begin
      syncMeta  <= rawState;
      curState  <= syncMeta;
      prevState <= curState;
    end
  end

  // Convert the Gray-coded phase pair to a 2-bit ring position.
  function automatic logic [1:0] ringPos(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  logic [1:0] stepDiff;
  assign stepDiff = ringPos(curState) - ringPos(prevState);

  always_comb begin
    strb.inc = (stepDiff == 2'd1);
    strb.dec = (stepDiff == 2'd3);
    strb.clr = !enable;
  end

  // R4: a change of both phases at once must never produce a count strobe.
  p_illegal_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((curState ^ prevState) == 2'b11) |-> !(strb.inc || strb.dec));
endmodule

// File: rtl/qenc_dp.sv
module qenc_dp
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  qencStrobes_t     strb,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= '0;
    else if (strb.clr) count <= '0;
    else if (strb.inc) count <= count + CNT_W'(1);
    else if (strb.dec) count <= count - CNT_W'(1);
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (count == '0));
  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.clr) |=> (count == $past(count) + CNT_W'(1)));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.clr) |=> (count == $past(count) - CNT_W'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inc && !strb.dec && !strb.clr) |=> $stable(count));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int OFF_W  = 3,
  parameter int CNT_W  = 32,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [NUM_IN-1:0] pinsIn,
  input  logic [SEL_W-1:0]  aSel,
  input  logic [OFF_W-1:0]  bOffset,
  output logic [CNT_W-1:0]  posCount
);
  qencStrobes_t strb;

  qenc_ctrl #(.NUM_IN(NUM_IN), .OFF_W(OFF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pinsIn(pinsIn),
    .aSel(aSel), .bOffset(bOffset), .strb(strb)
  );

  qenc_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(posCount)
  );
endmodule

// File: tb/tb_qenc_counter.sv
module tb_qenc_counter;
  logic        clk = 0;
  logic        rstN = 0;
  logic        enable = 0;
  logic [7:0]  pinsIn = '0;
  logic [2:0]  aSel = 3'd2;
  logic [2:0]  bOffset = 3'd1;
  logic [31:0] posCount;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  qenc_counter dut (
    .clk(clk), .rstN(rstN), .enable(enable), .pinsIn(pinsIn),
    .aSel(aSel), .bOffset(bOffset), .posCount(posCount)
  );

  // Each entry is {A, B, expected count}; A on pin 2, B on pin 3.
  localparam logic [33:0] VEC [16] = '{
    {2'b01, 32'd1}, {2'b11, 32'd2}, {2'b10, 32'd3}, {2'b00, 32'd4},
    {2'b01, 32'd5}, {2'b00, 32'd4}, {2'b10, 32'd3}, {2'b11, 32'd2},
    {2'b01, 32'd1}, {2'b00, 32'd0}, {2'b10, 32'hFFFF_FFFF}, {2'b11, 32'hFFFF_FFFE},
    {2'b00, 32'hFFFF_FFFE}, {2'b11, 32'hFFFF_FFFE}, {2'b10, 32'hFFFF_FFFF}, {2'b00, 32'd0}
  };

  task automatic check(input string req, input logic [31:0] exp);
    nChecks++;
    if (posCount !== exp) begin
      nFails++;
      $display("FAIL %s: posCount=%h expected=%h", req, posCount, exp);
    end
  endtask

  // Hold for three rising edges (R9 latency), then sample on a falling edge.
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int aPin, input int bPin, input logic a, input logic b);
    pinsIn[aPin] = a;
    pinsIn[bPin] = b;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset value", 32'd0);
    enable = 1;
    settle();

    // Table walk: R2 forward steps, R3 reverse steps, R4 double changes, R8 wrap.
    foreach (VEC[i]) begin
      drive(2, 3, VEC[i][33], VEC[i][32]);
      check($sformatf("R2/R3/R4/R8 vector %0d", i), VEC[i][31:0]);
    end

    // R7: pins other than the selected pair are ignored.
    pinsIn[5] = 1; pinsIn[0] = 1; settle();
    pinsIn[5] = 0; settle();
    check("R7 unselected pins ignored", 32'd0);
    pinsIn[0] = 0; settle();

    // R2: one full forward cycle gives +4.
    drive(2, 3, 0, 1); drive(2, 3, 1, 1); drive(2, 3, 1, 0); drive(2, 3, 0, 0);
    check("R2 full cycle is four counts", 32'd4);

    // R5: disable clears and holds at zero while phases move.
    enable = 0;
    @(negedge clk); @(negedge clk);
    check("R5 cleared on disable", 32'd0);
    drive(2, 3, 0, 1); drive(2, 3, 1, 1);
    check("R5 held at zero while disabled", 32'd0);
    drive(2, 3, 0, 1); drive(2, 3, 0, 0);

    // R6: re-enable resumes from zero.
    enable = 1; settle();
    drive(2, 3, 0, 1);
    check("R6 resumes from zero", 32'd1);

    // R7: positive offset wraps around the bank: A=pin 6, B=pin 0.
    enable = 0; pinsIn = '0; aSel = 3'd6; bOffset = 3'd2; settle();
    enable = 1; settle();
    drive(6, 0, 0, 1);
    check("R7 offset +2 wraps to pin 0", 32'd1);
    drive(6, 0, 1, 1);
    check("R7 offset +2 second step", 32'd2);

    // R7: negative offset: A=pin 0, B=pin 7.
    enable = 0; pinsIn = '0; aSel = 3'd0; bOffset = 3'b111; settle();
    enable = 1; settle();
    drive(0, 7, 1, 0);
    check("R7 R3 offset -1 reverse step", 32'hFFFF_FFFF);
    drive(0, 7, 0, 0);
    check("R7 offset -1 forward back to zero", 32'd0);

    // R9: the third rising edge after a change must show it.
    pinsIn[7] = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 latency three edges", 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R9: posCount=%h expected=run completion", posCount);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule